// File: doc/BRIEF.md
# Frame fetch DMA controller

This block produces the memory read addresses that feed a display refresh pipeline. It walks a frame buffer of `line_bursts` x `frame_lines` bursts, each burst being four 32-bit words (16 bytes). It requests one burst at a time and keeps its local word buffer below a fixed fill limit. It also raises four single-cycle event pulses: the first and last burst of a frame accepted from memory, and the first and last word of a frame taken by the panel side. These events feed a sticky status vector and a masked interrupt line.

Software programs a frame base address and a horizontal panning offset through a small write port. Both are held in working copies that reload only at the internal end of a frame, which is the acceptance of the last burst. A write therefore never disturbs the frame being fetched. Because fetching runs ahead of the panel, a write made after that reload point, even one made before the panel finishes the frame, takes effect one frame later. Within a frame the top ten address bits stay fixed and the lower 22 bits wrap inside a 4 MiB window.

Top module: `frame_fetch_dma`

## Requirements
- R1: After reset `rd_req`, all four event outputs, `evt_stat` and `irq` are low.
- R2: Each accepted burst (`rd_req` and `rd_ack` high at a clock edge) advances `rd_addr` by 16. After `line_bursts*frame_lines` accepted bursts the next request returns to the frame base. Bits [3:0] of the base register are ignored, and `rd_addr` holds while a request is waiting.
- R3: A write to the base register (address 0) leaves the current frame unchanged. The working copy loads at the edge that accepts the last burst of a frame, so a later write applies only from the frame after the next one.
- R4: `rd_addr[31:22]` is constant for a whole frame. `rd_addr[21:0]` wraps modulo 2^22.
- R5: The panning register (address 1) is in bits. When it is latched, its low bits are cleared according to the pixel mode in control bits [3:1] (0:1 bpp none, 1:2 bpp 2 bits, 2:4 bpp 3 bits, 3:8 bpp and 4:12 bpp 4 bits, 5 to 7:16 bpp 5 bits). Each full 128 bits of the aligned value adds 16 bytes to the frame base, and the remainder appears on `pan_frac`. It reloads at the same moment as the base.
- R6: `evt_fetch_first` and `evt_fetch_last` pulse for one cycle, in the cycle after the acceptance of burst 0 and of the last burst of a frame.
- R7: `evt_pnl_first` and `evt_pnl_last` pulse in the cycle after `pnl_word` takes word 0 and word `4*line_bursts*frame_lines-1` of a frame. `pnl_word` is ignored while the buffer is empty.
- R8: Buffered words rise by 4 per accepted burst and fall by 1 per taken panel word. `rd_req` is high only while at most DEPTH-4 words (28 by default) are buffered.
- R9: `evt_stat` bits [0] fetch-first, [1] fetch-last, [2] panel-first and [3] panel-last set in the cycle after their event and stay set. Writing 1s to address 3 clears them, and a new event wins over a clear in the same cycle.
- R10: `irq` is high while any `evt_stat` bit is set whose mask bit (address 4, bits [3:0]) is set.
- R11: Control bit 0 (address 2) enables the block. Setting it reloads both working copies and resets the counters and the buffer level, with the first request one cycle later. Clearing it drops `rd_req` after that write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (0 base, 1 pan, 2 control, 3 status clear, 4 mask) |
| wr_data | input | 32 | Write data |
| line_bursts | input | LB_W | Bursts per line |
| frame_lines | input | LN_W | Lines per frame |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | 32 | Burst start byte address |
| rd_ack | input | 1 | Memory accepts the request |
| pnl_word | input | 1 | Panel side takes one word |
| pan_frac | output | 7 | Sub-burst pan bits for the current fetch frame |
| evt_fetch_first | output | 1 | First burst of a frame accepted |
| evt_fetch_last | output | 1 | Last burst of a frame accepted |
| evt_pnl_first | output | 1 | First word of a frame taken by the panel |
| evt_pnl_last | output | 1 | Last word of a frame taken by the panel |
| evt_stat | output | 4 | Sticky event status |
| irq | output | 1 | Masked interrupt |

## Verification
A frame counter that is off by one first shows as a wrong address on the fifth burst, and as a fetch-last pulse after the wrong acceptance, within one frame of enabling. A working copy that loads at the wrong time shows at the first burst after a mid-frame write, either too early, or one frame late when it waits for the panel. A drifting buffer level shows within about eight bursts, as `rd_req` stalling early or failing to stall. A panel word counter advanced by an ignored strobe shifts every panel event by that many words.

// File: rtl/frame_fetch_dma.sv
module frame_fetch_dma #(
  parameter int LB_W  = 10,
  parameter int LN_W  = 10,
  parameter int PAN_W = 12,
  parameter int DEPTH = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [LB_W-1:0]  line_bursts,
  input  logic [LN_W-1:0]  frame_lines,
  output logic             rd_req,
  output logic [31:0]      rd_addr,
  input  logic             rd_ack,
  input  logic             pnl_word,
  output logic [6:0]       pan_frac,
  output logic             evt_fetch_first,
  output logic             evt_fetch_last,
  output logic             evt_pnl_first,
  output logic             evt_pnl_last,
  output logic [3:0]       evt_stat,
  output logic             irq
);
  localparam int FB_W = LB_W + LN_W;
  localparam int PW_W = FB_W + 2;
  localparam int LV_W = $clog2(DEPTH + 1);

  logic [31:0]      base_r;
  logic [PAN_W-1:0] pan_r;
  logic             en_r;
  logic [2:0]       mode_r;
  logic [3:0]       mask_r;
  logic [3:0]       stat_q;
  logic [3:0]       evt_q;
  logic             act_q;
  logic [31:0]      addr_q;
  logic [6:0]       frac_q;
  logic [FB_W-1:0]  fb_q;
  logic [PW_W-1:0]  pw_q;
  logic [LV_W-1:0]  lvl_q;

  logic [FB_W-1:0]  frame_bursts;
  logic [PW_W-1:0]  frame_words;
  logic             last_burst, last_word, fire, take, start_ev, reload;
  logic [6:0]       low_clr;
  logic [PAN_W-1:0] pan_al;
  logic [31:0]      next_base;
  logic [3:0]       stat_clr;

  assign frame_bursts = FB_W'(line_bursts) * FB_W'(frame_lines);
  assign frame_words  = {frame_bursts, 2'b00};
  assign last_burst   = (fb_q == frame_bursts - FB_W'(1));
  assign last_word    = (pw_q == frame_words - PW_W'(1));
  assign start_ev     = en_r & ~act_q;
  assign rd_req       = en_r & act_q & (lvl_q <= LV_W'(DEPTH - 4));
  assign fire         = rd_req & rd_ack;
  assign take         = en_r & act_q & pnl_word & (lvl_q != '0);
  assign reload       = start_ev | (fire & last_burst);

  always_comb begin
    case (mode_r)
      3'd0:    low_clr = 7'h00;
      3'd1:    low_clr = 7'h03;
      3'd2:    low_clr = 7'h07;
      3'd3,
      3'd4:    low_clr = 7'h0F;
      default: low_clr = 7'h1F;
    endcase
  end

  assign pan_al    = pan_r & ~{{(PAN_W-7){1'b0}}, low_clr};
  assign next_base = {base_r[31:4], 4'b0000} + (32'(pan_al >> 7) << 4);
  assign stat_clr  = (wr_en && wr_addr == 3'd3) ? wr_data[3:0] : 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_r <= '0;
      pan_r  <= '0;
      en_r   <= 1'b0;
      mode_r <= '0;
      mask_r <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: base_r <= wr_data;
        3'd1: pan_r  <= wr_data[PAN_W-1:0];
        3'd2: begin
          en_r   <= wr_data[0];
          mode_r <= wr_data[3:1];
        end
        3'd4: mask_r <= wr_data[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      frac_q <= '0;
      fb_q   <= '0;
    end else begin
      act_q <= en_r;
      if (reload) begin
        addr_q <= next_base;
        frac_q <= pan_al[6:0];
        fb_q   <= '0;
      end else if (fire) begin
        addr_q <= {addr_q[31:22], addr_q[21:0] + 22'd16};
        fb_q   <= fb_q + FB_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start_ev) begin
      pw_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (take) pw_q <= last_word ? '0 : pw_q + PW_W'(1);
      lvl_q <= lvl_q + (fire ? LV_W'(4) : '0) - (take ? LV_W'(1) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      stat_q <= '0;
    end else begin
      evt_q  <= {take & last_word, take & (pw_q == '0),
                 fire & last_burst, fire & (fb_q == '0)};
      stat_q <= (stat_q & ~stat_clr) | evt_q;
    end
  end

  assign rd_addr         = addr_q;
  assign pan_frac        = frac_q;
  assign evt_fetch_first = evt_q[0];
  assign evt_fetch_last  = evt_q[1];
  assign evt_pnl_first   = evt_q[2];
  assign evt_pnl_last    = evt_q[3];
  assign evt_stat        = stat_q;
  assign irq             = |(stat_q & mask_r);
endmodule

// File: rtl/frame_fetch_dma_chk.sv
module frame_fetch_dma_chk #(
  parameter int DEPTH = 32,
  parameter int LV_W  = 6
)(
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic            rd_ack,
  input logic [31:0]     rd_addr,
  input logic [3:0]      evt,
  input logic [3:0]      evt_stat,
  input logic [LV_W-1:0] lvl,
  input logic            wr_en,
  input logic [2:0]      wr_addr,
  input logic            off_bit
);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |=> (evt[1] || rd_addr[21:0] == $past(rd_addr[21:0]) + 22'd16));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> $stable(rd_addr));

  a_r4_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |=> (evt[1] || rd_addr[31:22] == $past(rd_addr[31:22])));

  a_r6_fetch_src: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] || evt[1]) |-> $past(rd_req && rd_ack));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LV_W'(DEPTH));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((evt_stat & $past(evt)) == $past(evt)));

  a_r11_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd2 && !off_bit) |=> !rd_req);
endmodule

bind frame_fetch_dma frame_fetch_dma_chk #(.DEPTH(DEPTH), .LV_W(LV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr),
  .evt({evt_pnl_last, evt_pnl_first, evt_fetch_last, evt_fetch_first}),
  .evt_stat(evt_stat), .lvl(lvl_q), .wr_en(wr_en), .wr_addr(wr_addr),
  .off_bit(wr_data[0])
);

// File: tb/test_frame_fetch_dma.sv
`timescale 1ns/1ps
module test_frame_fetch_dma;
  localparam int FB = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [2:0] wr_addr = 0; logic [31:0] wr_data = 0;
  logic [9:0] line_bursts = 10'd2, frame_lines = 10'd2;
  logic rd_req, rd_ack = 0, pnl_word = 0;
  logic [31:0] rd_addr;
  logic [6:0] pan_frac;
  logic evt_fetch_first, evt_fetch_last, evt_pnl_first, evt_pnl_last, irq;
  logic [3:0] evt_stat;

  frame_fetch_dma i_frame_fetch_dma (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_bursts(line_bursts), .frame_lines(frame_lines), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .pnl_word(pnl_word), .pan_frac(pan_frac),
    .evt_fetch_first(evt_fetch_first), .evt_fetch_last(evt_fetch_last),
    .evt_pnl_first(evt_pnl_first), .evt_pnl_last(evt_pnl_last),
    .evt_stat(evt_stat), .irq(irq));

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0;
  int ncyc, nacks, nwords;
  int ackb [0:1023];
  int wdi  [0:1023];
  logic [3:0]  ev   [0:1023];
  logic [31:0] acka [0:63];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit ack_on, input bit cons, input bit force_pw,
                     input bit we, input logic [2:0] wa, input logic [31:0] wd);
    int avail;
    @(negedge clk);
    if (ncyc < 1024) ev[ncyc] = {evt_pnl_last, evt_pnl_first, evt_fetch_last, evt_fetch_first};
    avail = 4*nacks - nwords;
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_ack = ack_on && rd_req;
    pnl_word = force_pw || (cons && avail > 0);
    if (ncyc < 1024) begin ackb[ncyc] = -1; wdi[ncyc] = -1; end
    if (rd_ack) begin
      if (ncyc < 1024) ackb[ncyc] = nacks % FB;
      if (nacks < 64) acka[nacks] = rd_addr;
      nacks++;
    end
    if (pnl_word && avail > 0) begin
      if (ncyc < 1024) wdi[ncyc] = nwords % (FB*4);
      nwords++;
    end
    ncyc++;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(0, 0, 0, 1, a, d);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 3'd0, 32'd0);
  endtask

  task automatic run_until(input int n, input bit cons);
    for (int g = 0; g < 400 && nacks < n; g++) cyc(1, cons, 0, 0, 3'd0, 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_ack = 0; pnl_word = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ncyc = 0; nacks = 0; nwords = 0;
  endtask

  task automatic check_addrs(input string tag, input logic [31:0] e[$]);
    for (int i = 0; i < e.size(); i++) chk(tag, acka[i], e[i]);
  endtask

  task automatic check_events(input string tag);
    int bad = 0;
    logic [3:0] exp;
    for (int c = 0; c + 1 < ncyc && c < 1023; c++) begin
      exp = {wdi[c] == FB*4-1, wdi[c] == 0, ackb[c] == FB-1, ackb[c] == 0};
      if (ev[c+1] !== exp) bad++;
    end
    chk(tag, bad, 0);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 events", {evt_pnl_last, evt_pnl_first, evt_fetch_last, evt_fetch_first}, 0);
    chk("R1 status", evt_stat, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_sequence_flow();
    logic [31:0] e[$];
    do_reset();
    wr(3'd0, 32'h0000_100C);
    wr(3'd2, 32'h0000_000B);
    for (int i = 0; i < 14; i++) cyc(1, 0, 0, 0, 3'd0, 32'd0);
    e = '{32'h1000, 32'h1010, 32'h1020, 32'h1030, 32'h1000, 32'h1010, 32'h1020, 32'h1030};
    check_addrs("R2 burst address", e);
    chk("R8 bursts before stall", nacks, 8);
    chk("R8 stalled", rd_req, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 3'd0, 32'd0);
    idle();
    chk("R8 resume after drain", rd_req, 1);
    check_events("R6 R7 events sequence");
  endtask

  task automatic t_shadow();
    logic [31:0] e[$];
    do_reset();
    wr(3'd0, 32'h1000);
    wr(3'd2, 32'h0B);
    run_until(2, 1);
    wr(3'd0, 32'h2000);
    run_until(4, 1);
    wr(3'd0, 32'h3000);
    run_until(12, 1);
    e = '{32'h1000, 32'h1010, 32'h1020, 32'h1030, 32'h2000, 32'h2010, 32'h2020, 32'h2030,
          32'h3000, 32'h3010, 32'h3020, 32'h3030};
    check_addrs("R3 shadow base", e);
    check_events("R6 R7 events shadow");
  endtask

  task automatic t_wrap();
    logic [31:0] e[$];
    do_reset();
    wr(3'd0, 32'h00BF_FFE0);
    wr(3'd2, 32'h0B);
    run_until(4, 1);
    e = '{32'h00BF_FFE0, 32'h00BF_FFF0, 32'h0080_0000, 32'h0080_0010};
    check_addrs("R4 window wrap", e);
  endtask

  task automatic t_pan();
    logic [31:0] e[$];
    do_reset();
    wr(3'd0, 32'h1000);
    wr(3'd1, 32'd300);
    wr(3'd2, 32'h07);
    run_until(1, 1);
    chk("R5 pan frac 8bpp", pan_frac, 7'd32);
    wr(3'd2, 32'h01);
    wr(3'd1, 32'd133);
    chk("R5 pan frac held", pan_frac, 7'd32);
    run_until(8, 1);
    e = '{32'h1020, 32'h1030, 32'h1040, 32'h1050, 32'h1010, 32'h1020, 32'h1030, 32'h1040};
    check_addrs("R5 pan address", e);
    chk("R5 pan frac 1bpp", pan_frac, 7'd5);
    do_reset();
    wr(3'd0, 32'h2000);
    wr(3'd1, 32'd184);
    wr(3'd2, 32'h09);
    run_until(1, 1);
    chk("R5 12bpp address", acka[0], 32'h2010);
    chk("R5 12bpp frac", pan_frac, 7'd48);
  endtask

  task automatic t_panel();
    do_reset();
    wr(3'd0, 32'h5000);
    wr(3'd2, 32'h0B);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 3'd0, 32'd0);
    for (int i = 0; i < 70; i++) cyc(1, 1, 0, 0, 3'd0, 32'd0);
    idle();
    check_events("R7 panel events, empty strobes ignored");
    chk("R7 words taken", nwords >= 32, 1);
  endtask

  task automatic t_status();
    do_reset();
    wr(3'd4, 32'h2);
    wr(3'd0, 32'h1000);
    wr(3'd2, 32'h0B);
    run_until(4, 0);
    idle(); idle();
    chk("R9 sticky status", evt_stat, 4'h3);
    chk("R10 irq masked on", irq, 1);
    wr(3'd3, 32'h2);
    idle();
    chk("R9 clear one bit", evt_stat, 4'h1);
    chk("R10 irq after clear", irq, 0);
    wr(3'd4, 32'h1);
    idle();
    chk("R10 irq new mask", irq, 1);
    wr(3'd3, 32'hF);
    idle();
    chk("R9 clear all", evt_stat, 4'h0);
    chk("R10 irq idle", irq, 0);
    wr(3'd2, 32'h0);
    idle();
    chk("R11 disable stops", rd_req, 0);
    wr(3'd0, 32'h4000);
    wr(3'd2, 32'h0B);
    run_until(nacks + 1, 0);
    chk("R11 restart at base", acka[nacks-1], 32'h4000);
  endtask

  initial begin
    #(8*150000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence_flow();
    t_shadow();
    t_wrap();
    t_pan();
    t_panel();
    t_status();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule